// File: doc/BRIEF.md
# Serial symbol framing aligner

This block sits behind a clock-recovery stage and receives one line bit per clock. A mode input chooses whether each bit is first turned from NRZI into NRZ or taken as it is. The resulting bits move through a ten-bit sliding window. Each clock, the window is compared against three fixed ten-bit delimiter pairs: a start-of-frame pair and two link-management pairs (Halt-Halt and Halt-Quiet). A match fixes the 5-bit symbol boundary. From then on, the block emits one aligned 5-bit symbol and the matching 10-bit pair every five bits.

While the framing-hold input is high, matches are ignored and the current boundary is kept. This protects data that is already being received from a spurious realignment. Each match is reported by a one-cycle flag that names the pattern which caused it. Symbol decoding and elastic buffering are left to later stages.

Top module: `symbol_aligner`

## Requirements
- R1: With `nrzi_bypass` high, the bit that enters the window is `line_bit` unchanged.
- R2: With `nrzi_bypass` low, the bit that enters the window is 1 when `line_bit` differs from the line bit of the previous clock, and 0 otherwise. The previous line bit is taken as 0 after reset.
- R3: When the ten most recent window bits, oldest first, are 1100010001 and hold is low, `hit_start` is high for exactly one cycle, in the cycle after the completing bit was sampled.
- R4: The pair 0010000100 (oldest first) raises `hit_halt_halt` for one cycle, with the same timing and hold rule as R3.
- R5: The pair 0010000000 (oldest first) raises `hit_halt_quiet` for one cycle, with the same timing and hold rule as R3.
- R6: A match sets a new boundary. `sym_valid` pulses in the cycle after the matching bit, and again after every further 5 bits. `sym_out` then holds the 5 most recent bits, with the earliest in bit 4.
- R7: Whenever `sym_valid` pulses, `pair_out` holds the 10 most recent bits, with the earliest in bit 9. Its low 5 bits equal `sym_out`.
- R8: While `frame_hold` is high during the sampling clock, a matching window raises no flag and does not move the boundary. Symbols keep their previous 5-bit spacing.
- R9: `sym_valid` never pulses before the first accepted match after reset. `aligned` goes high in the same cycle as the first flag and stays high.
- R10: A synchronous active-high `rst` clears the window, the NRZI history, `aligned`, `sym_valid`, all flags, `sym_out` and `pair_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Serial line bit, one per clock |
| nrzi_bypass | input | 1 | 1: take bits as NRZ; 0: decode NRZI |
| frame_hold | input | 1 | 1: ignore delimiter matches |
| sym_out | output | 5 | Aligned symbol, earliest bit in MSB |
| sym_valid | output | 1 | One-cycle strobe for sym_out and pair_out |
| pair_out | output | 10 | Last two symbols, earliest bit in MSB |
| aligned | output | 1 | A boundary has been established |
| hit_start | output | 1 | Start-of-frame pair matched |
| hit_halt_halt | output | 1 | Halt-Halt pair matched |
| hit_halt_quiet | output | 1 | Halt-Quiet pair matched |

## Verification
The bench places delimiters at bit offsets that are not multiples of five. A design that failed to restart its phase counter would therefore strobe symbols straddling the old boundary. It sends a start pair under hold at a shifted offset, where a design that ignored hold would shift every later strobe and raise a flag. NRZI runs are sent both with and without bypass. An inverted or missing history bit would then corrupt the window, so the delimiters would never match. The first match after reset is also checked, so that no strobe leaks out before alignment.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
    localparam int SYM_W   = 5;
    localparam int PAIR_W  = 2 * SYM_W;
    localparam int NUM_PAT = 3;
    localparam int CNT_W   = $clog2(SYM_W);

    typedef logic [PAIR_W-1:0] pair_t;

    localparam int IDX_START = 0;
    localparam int IDX_HH    = 1;
    localparam int IDX_HQ    = 2;

    localparam pair_t PAT_START = 10'b11000_10001;
    localparam pair_t PAT_HH    = 10'b00100_00100;
    localparam pair_t PAT_HQ    = 10'b00100_00000;

    function automatic pair_t pattern_at(input int idx);
        case (idx)
            IDX_START: return PAT_START;
            IDX_HH:    return PAT_HH;
            default:   return PAT_HQ;
        endcase
    endfunction
endpackage

// File: rtl/nrzi_to_nrz.sv
module nrzi_to_nrz (
    input  logic clk,
    input  logic rst,
    input  logic line_bit,
    input  logic bypass,
    output logic nrz_bit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = line_bit;
        nrz_bit = bypass ? line_bit : (line_bit ^ prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/delimiter_match.sv
module delimiter_match
    import aligner_pkg::*;
(
    input  pair_t              window,
    input  logic               enable,
    output logic [NUM_PAT-1:0] hit
);
    for (genvar i = 0; i < NUM_PAT; i++) begin : g_pat
        assign hit[i] = enable && (window == pattern_at(i));
    end
endmodule

// File: rtl/symbol_aligner.sv
module symbol_aligner
    import aligner_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_bit,
    input  logic              nrzi_bypass,
    input  logic              frame_hold,
    output logic [SYM_W-1:0]  sym_out,
    output logic              sym_valid,
    output logic [PAIR_W-1:0] pair_out,
    output logic              aligned,
    output logic              hit_start,
    output logic              hit_halt_halt,
    output logic              hit_halt_quiet
);
    localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(SYM_W - 1);

    typedef struct packed {
        pair_t              sr;
        logic [CNT_W-1:0]   cnt;
        logic               aligned;
        logic [SYM_W-1:0]   sym;
        pair_t              pair;
        logic               valid;
        logic [NUM_PAT-1:0] hit;
    } state_t;

    state_t             st_d, st_q;
    logic               nrz;
    pair_t              window;
    logic [NUM_PAT-1:0] match;
    logic               take;
    logic               boundary;

    nrzi_to_nrz u_nrzi (
        .clk      (clk),
        .rst      (rst),
        .line_bit (line_bit),
        .bypass   (nrzi_bypass),
        .nrz_bit  (nrz)
    );

    assign window = {st_q.sr[PAIR_W-2:0], nrz};

    delimiter_match u_match (
        .window (window),
        .enable (!frame_hold),
        .hit    (match)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sr    = window;
        st_d.hit   = match;
        st_d.valid = 1'b0;
        take       = |match;
        boundary   = take || (st_q.cnt == LAST_PHASE);

        if (take) begin
            st_d.aligned = 1'b1;
            st_d.cnt     = '0;
        end else if (st_q.cnt == LAST_PHASE) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (boundary && (st_q.aligned || take)) begin
            st_d.valid = 1'b1;
            st_d.sym   = window[SYM_W-1:0];
            st_d.pair  = window;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sym_out        = st_q.sym;
    assign sym_valid      = st_q.valid;
    assign pair_out       = st_q.pair;
    assign aligned        = st_q.aligned;
    assign hit_start      = st_q.hit[IDX_START];
    assign hit_halt_halt  = st_q.hit[IDX_HH];
    assign hit_halt_quiet = st_q.hit[IDX_HQ];
endmodule

// File: rtl/symbol_aligner_chk.sv
module symbol_aligner_chk
    import aligner_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_hold,
    input logic [SYM_W-1:0]  sym_out,
    input logic              sym_valid,
    input logic [PAIR_W-1:0] pair_out,
    input logic              aligned,
    input logic              hit_start,
    input logic              hit_halt_halt,
    input logic              hit_halt_quiet
);
    logic any_hit;
    assign any_hit = hit_start || hit_halt_halt || hit_halt_quiet;

    p_one_flag_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_start, hit_halt_halt, hit_halt_quiet}));

    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        frame_hold |=> !any_hit);

    p_valid_after_align_r9: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> aligned);

    p_aligned_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        aligned |=> aligned);

    p_pair_low_r7: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (pair_out[SYM_W-1:0] == sym_out));

    p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> (!sym_valid || any_hit));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!sym_valid && !aligned && !any_hit));
endmodule

bind symbol_aligner symbol_aligner_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .frame_hold     (frame_hold),
    .sym_out        (sym_out),
    .sym_valid      (sym_valid),
    .pair_out       (pair_out),
    .aligned        (aligned),
    .hit_start      (hit_start),
    .hit_halt_halt  (hit_halt_halt),
    .hit_halt_quiet (hit_halt_quiet)
);

// File: tb/symbol_aligner_test.sv
`timescale 1ns/1ps
module symbol_aligner_test;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       line_bit = 1'b0;
    logic       nrzi_bypass = 1'b1;
    logic       frame_hold = 1'b0;
    logic [4:0] sym_out;
    logic       sym_valid;
    logic [9:0] pair_out;
    logic       aligned;
    logic       hit_start, hit_halt_halt, hit_halt_quiet;

    always #2.5 clk = ~clk;

    symbol_aligner uut (
        .clk(clk), .rst(rst), .line_bit(line_bit), .nrzi_bypass(nrzi_bypass),
        .frame_hold(frame_hold), .sym_out(sym_out), .sym_valid(sym_valid),
        .pair_out(pair_out), .aligned(aligned), .hit_start(hit_start),
        .hit_halt_halt(hit_halt_halt), .hit_halt_quiet(hit_halt_quiet)
    );

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    int m_prev;
    int m_hist[$];
    int m_phase;
    int m_aligned;
    int e_valid, e_sym, e_pair, e_hs, e_hh, e_hq, e_aligned;
    int enc_line;

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R6", {cur_req, " sym_valid"}, int'(sym_valid), e_valid);
        check("R6", {cur_req, " sym_out"}, int'(sym_out), e_sym);
        check("R7", {cur_req, " pair_out"}, int'(pair_out), e_pair);
        check("R3", {cur_req, " hit_start"}, int'(hit_start), e_hs);
        check("R4", {cur_req, " hit_halt_halt"}, int'(hit_halt_halt), e_hh);
        check("R5", {cur_req, " hit_halt_quiet"}, int'(hit_halt_quiet), e_hq);
        check("R9", {cur_req, " aligned"}, int'(aligned), e_aligned);
    endtask

    task automatic model_reset();
        m_prev = 0;
        m_hist = {};
        for (int k = 0; k < 10; k++) m_hist.push_back(0);
        m_phase = 0; m_aligned = 0;
        e_valid = 0; e_sym = 0; e_pair = 0;
        e_hs = 0; e_hh = 0; e_hq = 0; e_aligned = 0;
        enc_line = 0;
    endtask

    task automatic model_step(input int b, input int byp, input int hold);
        int nrz, win, take, edge_here;
        nrz = byp ? b : (b ^ m_prev);
        m_prev = b;
        m_hist.push_back(nrz);
        void'(m_hist.pop_front());
        win = 0;
        foreach (m_hist[k]) win = win * 2 + m_hist[k];
        e_hs = (!hold && win == 'h311) ? 1 : 0;
        e_hh = (!hold && win == 'h084) ? 1 : 0;
        e_hq = (!hold && win == 'h080) ? 1 : 0;
        take = e_hs | e_hh | e_hq;
        edge_here = take || (m_phase == 4);
        if (take) begin m_phase = 0; m_aligned = 1; end
        else m_phase = (m_phase + 1) % 5;
        e_valid = (edge_here && m_aligned) ? 1 : 0;
        if (e_valid) begin e_sym = win & 31; e_pair = win; end
        e_aligned = m_aligned;
    endtask

    task automatic step(input int b, input int byp, input int hold);
        @(negedge clk);
        compare_all();
        line_bit = b[0]; nrzi_bypass = byp[0]; frame_hold = hold[0];
        model_step(b, byp, hold);
    endtask

    // R10: reset clears everything
    task automatic do_reset(input int byp);
        @(negedge clk);
        rst = 1'b1; line_bit = 1'b0; frame_hold = 1'b0; nrzi_bypass = byp[0];
        model_reset();
        repeat (3) @(negedge clk);
        cur_req = "R10";
        compare_all();
        rst = 1'b0;
        model_step(0, byp, 0);
    endtask

    // send NRZ bits MSB first; with byp=0 they are NRZI-encoded on the line (R2)
    task automatic send(input logic [31:0] v, input int n, input int byp, input int hold);
        for (int k = n - 1; k >= 0; k--) begin
            if (byp) step(int'(v[k]), 1, hold);
            else begin
                enc_line = enc_line ^ int'(v[k]);
                step(enc_line, 0, hold);
            end
        end
    endtask

    initial begin
        #(5ns * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10 reset state, R9 no strobes before alignment
        do_reset(1);
        cur_req = "R9";
        send(32'h0000_2AB5, 17, 1, 0);

        // R1 bypass: start pair at odd offset, then data symbols (R3, R6, R7)
        cur_req = "R1";
        send(32'h0000_0005, 3, 1, 0);
        send(32'h0000_0311, 10, 1, 0);
        send(32'h1234_5678, 32, 1, 0);

        // R8 hold: start pair at shifted offset is ignored
        cur_req = "R8";
        send(32'h0000_0003, 2, 1, 1);
        send(32'h0000_0311, 10, 1, 1);
        send(32'h0000_ABCD, 16, 1, 0);

        // R4 Halt-Halt and R5 Halt-Quiet
        cur_req = "R4";
        send(32'h0000_0001, 1, 1, 0);
        send(32'h0000_0084, 10, 1, 0);
        send(32'h0000_5A5A, 16, 1, 0);
        cur_req = "R5";
        send(32'h0000_0006, 3, 1, 0);
        send(32'h0000_0080, 10, 1, 0);
        send(32'h0000_F0F0, 16, 1, 0);

        // R2 NRZI decoding after reset
        do_reset(0);
        cur_req = "R2";
        send(32'h0000_0033, 7, 0, 0);
        send(32'h0000_0311, 10, 0, 0);
        send(32'h0BAD_CAFE, 32, 0, 0);
        send(32'h0000_0084, 10, 0, 0);
        send(32'h0000_1357, 16, 0, 0);

        // random stream mixing modes
        cur_req = "R6";
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom_range(0, 15));
            step(r & 1, (k / 100) % 2, (r == 15) ? 1 : 0);
        end

        @(negedge clk);
        compare_all();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule